// File: doc/BRIEF.md
# Two-way write-back data cache controller with three-state coherency

This block is the data cache of a single processor core. It holds 8 KB of data in two ways of 128 sets. Each line is 32 bytes and moves on the memory port as four 64-bit beats. The CPU side sends one 64-bit load or store at a time. Each store carries its own write policy flag, so the policy is chosen per access. A write-back store only dirties the cache. A write-through store also sends one beat straight to memory.

Misses are served as follows:
- A valid victim holding dirty data is first written out as a burst castout.
- The missing line is then fetched as a burst. The fetch starts at the requested beat and wraps around the line, so a load is answered as soon as its own beat arrives.

A line is always invalid, exclusive or modified. Because there is no shared state, an external snoop that hits the cache removes the line. A dirty line is first flushed while a retry indication is asserted.

The address splits into three fields. Bits [4:3] select the beat within a line, bits [11:5] select the set, and bits [31:12] form the tag.

Top module: `dcache_mei`

## Requirements
- R1: After reset every line is invalid. `cpu_ready_o` is high and `mem_req_o` is low.
- R2: The address fields are: beat = addr[4:3], set = addr[11:5], tag = addr[31:12]. A load that hits returns the stored doubleword with no memory traffic.
- R3: A load miss fetches the line as a four-beat burst. The first beat is the requested beat, and the beat number then increments modulo 4. The load is answered with the data of that first beat, and the line ends up exclusive.
- R4: A hit or a line fill makes that way the most recently used way of its set. A miss replaces the lowest-numbered invalid way if there is one, and otherwise the least recently used way.
- R5: A write-back store that hits updates the line and marks it modified, with no memory traffic. A write-back store that misses fetches the line, merges the store data and leaves the line modified.
- R6: A write-through store issues exactly one single-beat memory write carrying the store data. On a hit it also updates the line and leaves the line state unchanged. On a miss it allocates nothing.
- R7: A victim that is modified is written out as a four-beat burst in beat order 0,1,2,3 before the fill starts. A victim that is not modified is dropped without a write.
- R8: A snoop that hits a modified line asserts `snoop_retry_o` while the line is written out as a four-beat burst, and then invalidates the line.
- R9: A snoop that hits an exclusive line invalidates it without memory traffic. A snoop that misses changes nothing.
- R10: A memory beat completes on a cycle with `mem_ack_i` high. While the acknowledge is low, the request, address and direction hold steady. Single-beat requests are always writes.
- R11: `resp_valid_o` is a one-cycle pulse per request. `cpu_ready_o` is high only when the controller is idle and no snoop is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU request, taken when `cpu_ready_o` is high |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_wt_i | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| cpu_addr_i | input | 32 | Byte address of the doubleword |
| cpu_wdata_i | input | 64 | Store data |
| cpu_ready_o | output | 1 | Controller can take a CPU request |
| resp_valid_o | output | 1 | Request finished (one-cycle pulse) |
| resp_rdata_o | output | 64 | Load data, valid with `resp_valid_o` |
| snoop_valid_i | input | 1 | Snoop request, taken when `snoop_ready_o` is high |
| snoop_addr_i | input | 32 | Snooped address |
| snoop_ready_o | output | 1 | Controller can take a snoop |
| snoop_retry_o | output | 1 | Snooped line is dirty and being flushed |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_burst_o | output | 1 | Beat is part of a four-beat line transfer |
| mem_addr_o | output | 32 | Byte address of the current beat |
| mem_wdata_o | output | 64 | Write beat data |
| mem_ack_i | input | 1 | Current beat completes this cycle |
| mem_rdata_i | input | 64 | Read beat data, valid with `mem_ack_i` |

## Verification
The assertions check the memory-port and handshake properties on every cycle:
- the port holds steady while a beat waits for its acknowledge;
- a single-beat request is always a write;
- a retry is always backed by a burst write;
- responses are single-cycle pulses, and no request is taken while memory traffic runs.

Replacement order, critical-beat ordering, castout order and the state left after each store policy or snoop cannot be seen in one cycle. The bench's access sequences show them by counting memory beats, recording the first beat address of each burst, and comparing the data of later accesses against an independent model of memory.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_E = 2'd1,
    LINE_M = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_SNOOP,
    S_CAST,
    S_FILL,
    S_WT
  } fsm_e;
endpackage

// File: rtl/dc_dir.sv
// Tag, state and LRU directory; hit and victim selection.
module dc_dir
  import dc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 128,
  parameter int TAG_W = 20,
  parameter int IDX_W = 7,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output line_st_e         hit_st_o,
  output logic [WAY_W-1:0] vic_way_o,
  output line_st_e         vic_st_o,
  output logic [TAG_W-1:0] vic_tag_o,
  input  logic             st_we_i,
  input  logic             tag_we_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  line_st_e         st_i,
  input  logic             lru_we_i,
  input  logic [WAY_W-1:0] mru_way_i
);
  logic [WAYS-1:0]  match, empty;
  line_st_e         way_st  [WAYS];
  logic [TAG_W-1:0] way_tag [WAYS];
  logic [WAY_W-1:0] lru_q   [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    line_st_e         st_q  [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) st_q[s] <= LINE_I;
      end else if (st_we_i && wr_way_i == WAY_W'(w)) begin
        st_q[idx_i] <= st_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (tag_we_i && wr_way_i == WAY_W'(w)) tag_q[idx_i] <= tag_i;
    end

    assign way_st[w]  = st_q[idx_i];
    assign way_tag[w] = tag_q[idx_i];
    assign empty[w]   = (st_q[idx_i] == LINE_I);
    assign match[w]   = !empty[w] && (tag_q[idx_i] == tag_i);
  end

  // lru_q holds the way to replace next (two ways: the other one)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else if (lru_we_i) begin
      lru_q[idx_i] <= ~mru_way_i;
    end
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) if (match[w]) hit_way_o = WAY_W'(w);
    vic_way_o = lru_q[idx_i];
    for (int w = WAYS - 1; w >= 0; w--) if (empty[w]) vic_way_o = WAY_W'(w);
  end

  assign hit_o     = |match;
  assign hit_st_o  = way_st[hit_way_o];
  assign vic_st_o  = way_st[vic_way_o];
  assign vic_tag_o = way_tag[vic_way_o];
endmodule

// File: rtl/dc_data.sv
// Line data storage, one register array per way.
module dc_data #(
  parameter int WAYS   = 2,
  parameter int DEPTH  = 512,
  parameter int DATA_W = 64,
  parameter int AW     = 9,
  parameter int WAY_W  = 1
) (
  input  logic              clk_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] rd_word [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DATA_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wr_way_i == WAY_W'(w)) mem_q[wr_addr_i] <= wr_data_i;
    end
    assign rd_word[w] = mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_word[rd_way_i];
endmodule

// File: rtl/dcache_mei.sv
module dcache_mei
  import dc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  parameter int BEATS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              cpu_wt_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              snoop_ready_o,
  output logic              snoop_retry_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - BEAT_W - IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  fsm_e              state_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic              op_we_q, op_wt_q, snoop_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  op_tag;
  logic [IDX_W-1:0]  op_idx;
  logic [BEAT_W-1:0] op_beat, fill_beat, rd_beat, wr_beat;
  logic              unused_lsb;

  assign op_tag     = op_addr_q[ADDR_W-1 -: TAG_W];
  assign op_idx     = op_addr_q[OFF_W+BEAT_W +: IDX_W];
  assign op_beat    = op_addr_q[OFF_W +: BEAT_W];
  assign fill_beat  = op_beat + cnt_q;
  assign unused_lsb = ^op_addr_q[OFF_W-1:0];

  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way, rd_way, wr_way;
  line_st_e         hit_st, vic_st, st_new;
  logic [TAG_W-1:0] vic_tag;
  logic             st_we, tag_we, lru_we, d_we;
  logic [WAY_W-1:0] mru_way, d_way;
  logic [DATA_W-1:0] d_rdata, d_wdata;

  dc_dir #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) i_dir (
    .clk_i, .rst_ni,
    .idx_i(op_idx), .tag_i(op_tag),
    .hit_o(hit), .hit_way_o(hit_way), .hit_st_o(hit_st),
    .vic_way_o(vic_way), .vic_st_o(vic_st), .vic_tag_o(vic_tag),
    .st_we_i(st_we), .tag_we_i(tag_we), .wr_way_i(wr_way), .st_i(st_new),
    .lru_we_i(lru_we), .mru_way_i(mru_way)
  );

  dc_data #(
    .WAYS(WAYS), .DEPTH(SETS * BEATS), .DATA_W(DATA_W),
    .AW(IDX_W + BEAT_W), .WAY_W(WAY_W)
  ) i_data (
    .clk_i,
    .rd_way_i(rd_way), .rd_addr_i({op_idx, rd_beat}), .rd_data_o(d_rdata),
    .we_i(d_we), .wr_way_i(d_way), .wr_addr_i({op_idx, wr_beat}),
    .wr_data_i(d_wdata)
  );

  assign rd_way  = (state_q == S_CAST) ? way_q : hit_way;
  assign rd_beat = (state_q == S_CAST) ? cnt_q : op_beat;

  always_comb begin
    st_we = 1'b0; tag_we = 1'b0; wr_way = way_q; st_new = LINE_I;
    lru_we = 1'b0; mru_way = way_q;
    d_we = 1'b0; d_way = way_q; wr_beat = op_beat; d_wdata = op_wdata_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_burst_o = 1'b0;
    mem_addr_o = '0; mem_wdata_o = d_rdata;
    unique case (state_q)
      S_LOOK: if (hit) begin
        lru_we = 1'b1; mru_way = hit_way;
        if (op_we_q) begin
          d_we = 1'b1; d_way = hit_way;
          if (!op_wt_q) begin
            st_we = 1'b1; wr_way = hit_way; st_new = LINE_M;
          end
        end
      end
      S_SNOOP: if (hit && hit_st == LINE_E) begin
        st_we = 1'b1; wr_way = hit_way;
      end
      S_CAST: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_burst_o = 1'b1;
        mem_addr_o = {vic_tag_q, op_idx, cnt_q, OFF_W'(0)};
        if (mem_ack_i && cnt_q == LAST && snoop_q) st_we = 1'b1;
      end
      S_FILL: begin
        mem_req_o = 1'b1; mem_burst_o = 1'b1;
        mem_addr_o = {op_tag, op_idx, fill_beat, OFF_W'(0)};
        if (mem_ack_i) begin
          d_we = 1'b1; wr_beat = fill_beat;
          d_wdata = (op_we_q && fill_beat == op_beat) ? op_wdata_q : mem_rdata_i;
          if (cnt_q == LAST) begin
            st_we = 1'b1; tag_we = 1'b1; lru_we = 1'b1;
            st_new = op_we_q ? LINE_M : LINE_E;
          end
        end
      end
      S_WT: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = {op_addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
        mem_wdata_o = op_wdata_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; op_addr_q <= '0; op_we_q <= 1'b0; op_wt_q <= 1'b0;
      snoop_q <= 1'b0; op_wdata_q <= '0; way_q <= '0; vic_tag_q <= '0;
      cnt_q <= '0; resp_valid_q <= 1'b0; rdata_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (snoop_valid_i) begin
            op_addr_q <= snoop_addr_i; snoop_q <= 1'b1; state_q <= S_SNOOP;
          end else if (cpu_req_i) begin
            op_addr_q <= cpu_addr_i; op_we_q <= cpu_we_i; op_wt_q <= cpu_wt_i;
            op_wdata_q <= cpu_wdata_i; snoop_q <= 1'b0; state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            if (op_we_q && op_wt_q) begin
              state_q <= S_WT;
            end else begin
              resp_valid_q <= 1'b1; rdata_q <= d_rdata; state_q <= S_IDLE;
            end
          end else if (op_we_q && op_wt_q) begin
            state_q <= S_WT;
          end else begin
            way_q <= vic_way; vic_tag_q <= vic_tag;
            state_q <= (vic_st == LINE_M) ? S_CAST : S_FILL;
          end
        end
        S_SNOOP: begin
          if (hit && hit_st == LINE_M) begin
            way_q <= hit_way; vic_tag_q <= op_tag; state_q <= S_CAST;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_CAST: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= snoop_q ? S_IDLE : S_FILL;
        end
        S_FILL: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0 && !op_we_q) begin
            resp_valid_q <= 1'b1; rdata_q <= mem_rdata_i;
          end
          if (cnt_q == LAST) begin
            if (op_we_q) resp_valid_q <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_WT: if (mem_ack_i) begin
          resp_valid_q <= 1'b1; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready_o   = (state_q == S_IDLE) && !snoop_valid_i;
  assign snoop_ready_o = (state_q == S_IDLE);
  assign snoop_retry_o = (state_q == S_CAST) && snoop_q;
  assign resp_valid_o  = resp_valid_q;
  assign resp_rdata_o  = rdata_q;
endmodule

// File: rtl/dcache_mei_chk.sv
module dcache_mei_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_ready_o,
  input logic              resp_valid_o,
  input logic              snoop_retry_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_burst_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);
  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R10
  single_is_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_burst_o |-> mem_we_o);

  // R8
  retry_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_retry_o |-> mem_req_o && mem_we_o && mem_burst_o);

  // R11
  resp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);

  // R11
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !mem_req_o && !snoop_retry_o);
endmodule

bind dcache_mei dcache_mei_chk #(.ADDR_W(ADDR_W)) i_dcache_mei_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_ready_o(cpu_ready_o),
  .resp_valid_o(resp_valid_o), .snoop_retry_o(snoop_retry_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_burst_o(mem_burst_o),
  .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i)
);

// File: tb/test_dcache_mei.sv
module test_dcache_mei;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0, cpu_wt_i = 1'b0;
  logic [31:0] cpu_addr_i = '0;
  logic [63:0] cpu_wdata_i = '0;
  logic        cpu_ready_o, resp_valid_o;
  logic [63:0] resp_rdata_o;
  logic        snoop_valid_i = 1'b0;
  logic [31:0] snoop_addr_i = '0;
  logic        snoop_ready_o, snoop_retry_o;
  logic        mem_req_o, mem_we_o, mem_burst_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  dcache_mei i_dcache_mei (.*);

  int tests = 0, fails = 0;
  int n_rd = 0, n_wr = 0, n_single = 0, n_retry = 0;
  int s_rd, s_wr, s_single, s_retry;
  int rd_pos = 0, wr_pos = 0;
  logic [31:0] first_rd_addr = '0, first_wr_addr = '0;
  bit phase = 1'b0;

  logic [63:0] ext  [logic [31:0]];
  logic [63:0] refm [logic [31:0]];
  bit          chk_q [$];
  logic [63:0] dat_q [$];
  string       req_q [$];

  function automatic logic [63:0] init_word(input logic [31:0] a);
    return {a, ~a};
  endfunction
  function automatic logic [63:0] ext_rd(input logic [31:0] a);
    return ext.exists(a) ? ext[a] : init_word(a);
  endfunction
  function automatic logic [63:0] ref_rd(input logic [31:0] a);
    return refm.exists(a) ? refm[a] : init_word(a);
  endfunction
  function automatic logic [31:0] ad(input logic [19:0] t, input logic [6:0] i,
                                     input logic [1:0] b);
    return {t, i, b, 3'b000};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // memory model: one beat per two cycles
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      mem_ack_i = 1'b0; phase = 1'b0;
    end else begin
      if (mem_req_o && phase) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          ext[mem_addr_o] = mem_wdata_o; n_wr++;
          if (!mem_burst_o) n_single++;
          else begin
            if (wr_pos == 0) first_wr_addr = mem_addr_o;
            wr_pos = (wr_pos + 1) % 4;
          end
        end else begin
          mem_rdata_i = ext_rd(mem_addr_o); n_rd++;
          if (rd_pos == 0) first_rd_addr = mem_addr_o;
          rd_pos = (rd_pos + 1) % 4;
        end
      end else begin
        mem_ack_i = 1'b0;
      end
      phase = ~phase;
      if (snoop_retry_o) n_retry++;
    end
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && resp_valid_o) begin
      if (chk_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R11: actual unexpected response expected none");
      end else begin
        automatic bit c = chk_q.pop_front();
        automatic logic [63:0] d = dat_q.pop_front();
        automatic string r = req_q.pop_front();
        if (c) chk(r, resp_rdata_o, d);
      end
    end
  end

  task automatic snap();
    s_rd = n_rd; s_wr = n_wr; s_single = n_single; s_retry = n_retry;
  endtask

  task automatic traffic(input string r, input int rd, input int wr);
    chk({r, " read beats"}, 64'(n_rd - s_rd), 64'(rd));
    chk({r, " write beats"}, 64'(n_wr - s_wr), 64'(wr));
  endtask

  task automatic cpu_op(input bit we, input bit wt, input logic [31:0] a,
                        input logic [63:0] d, input string r);
    @(negedge clk_i);
    while (!cpu_ready_o) @(negedge clk_i);
    snap();
    chk_q.push_back(!we); dat_q.push_back(we ? 64'd0 : ref_rd(a)); req_q.push_back(r);
    if (we) refm[a] = d;
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_wt_i = wt; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk_i);
    cpu_req_i = 1'b0;
    while (chk_q.size() != 0) @(negedge clk_i);
    while (!cpu_ready_o) @(negedge clk_i);
  endtask

  task automatic snoop(input logic [31:0] a);
    @(negedge clk_i);
    while (!snoop_ready_o) @(negedge clk_i);
    snap();
    snoop_valid_i = 1'b1; snoop_addr_i = a;
    #1 chk("R11 ready low with snoop pending", 64'(cpu_ready_o), 64'd0);
    @(negedge clk_i);
    snoop_valid_i = 1'b0;
    while (!cpu_ready_o) @(negedge clk_i);
  endtask

  localparam logic [63:0] X_VAL = 64'hA5A5_0001_DEAD_BEEF;
  localparam logic [63:0] Y_VAL = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] Z_VAL = 64'h0F0F_F0F0_5555_AAAA;
  localparam logic [63:0] W_VAL = 64'hCAFE_0000_1111_2222;

  initial begin
    repeat (100000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 ready after reset", 64'(cpu_ready_o), 64'd1);
    chk("R1 no memory request", 64'(mem_req_o), 64'd0);

    // R3: load miss, critical beat first
    cpu_op(0, 0, ad(1, 5, 2), 0, "R3 load miss data");
    traffic("R3", 4, 0);
    chk("R3 first fill beat", 64'(first_rd_addr), 64'(ad(1, 5, 2)));
    // R2: hit
    cpu_op(0, 0, ad(1, 5, 0), 0, "R2 load hit data");
    traffic("R2", 0, 0);
    // R5: write-back store hit
    cpu_op(1, 0, ad(1, 5, 1), X_VAL, "R5 wb store");
    traffic("R5 hit", 0, 0);
    cpu_op(0, 0, ad(1, 5, 1), 0, "R5 read back");
    traffic("R5 read back", 0, 0);
    // R4: second line fills the empty way
    cpu_op(0, 0, ad(2, 5, 0), 0, "R4 fill way B");
    traffic("R4 fill", 4, 0);
    cpu_op(0, 0, ad(1, 5, 3), 0, "R4 A still present");
    traffic("R4 A kept", 0, 0);
    // R7: clean victim dropped; R4: LRU way chosen
    cpu_op(0, 0, ad(3, 5, 0), 0, "R7 clean evict");
    traffic("R7 clean victim", 4, 0);
    cpu_op(0, 0, ad(1, 5, 0), 0, "R4 MRU kept");
    traffic("R4 MRU kept", 0, 0);
    cpu_op(0, 0, ad(2, 5, 0), 0, "R4 refill B");
    traffic("R4 refill", 4, 0);
    // R7: dirty victim castout
    cpu_op(0, 0, ad(4, 5, 0), 0, "R7 fill after castout");
    traffic("R7 dirty victim", 4, 4);
    chk("R7 castout beat order", 64'(first_wr_addr), 64'(ad(1, 5, 0)));
    chk("R7 castout data", ext_rd(ad(1, 5, 1)), X_VAL);
    // R6: write-through hit
    cpu_op(1, 1, ad(2, 5, 2), Y_VAL, "R6 wt store");
    traffic("R6 wt hit", 0, 1);
    chk("R6 single beat", 64'(n_single - s_single), 64'd1);
    chk("R6 memory updated", ext_rd(ad(2, 5, 2)), Y_VAL);
    cpu_op(0, 0, ad(2, 5, 2), 0, "R6 line updated");
    traffic("R6 line updated", 0, 0);
    // R9: snoop exclusive (R6 left it exclusive)
    snoop(ad(2, 5, 0));
    traffic("R9 snoop exclusive", 0, 0);
    chk("R9 no retry", 64'(n_retry - s_retry), 64'd0);
    cpu_op(0, 0, ad(2, 5, 2), 0, "R9 refetch");
    traffic("R9 invalidated", 4, 0);
    // R6: write-through miss, no allocate
    cpu_op(1, 1, ad(5, 9, 1), Z_VAL, "R6 wt miss");
    traffic("R6 wt miss", 0, 1);
    cpu_op(0, 0, ad(5, 9, 1), 0, "R6 no allocate");
    traffic("R6 no allocate", 4, 0);
    // R5: write-back store miss allocates modified
    cpu_op(1, 0, ad(6, 20, 3), W_VAL, "R5 wb miss");
    traffic("R5 wb miss", 4, 0);
    // R8: snoop on modified
    snoop(ad(6, 20, 0));
    chk("R8 retry seen", 64'(n_retry - s_retry > 0), 64'd1);
    traffic("R8 flush", 0, 4);
    chk("R8 flushed data", ext_rd(ad(6, 20, 3)), W_VAL);
    cpu_op(0, 0, ad(6, 20, 3), 0, "R8 refetch");
    traffic("R8 invalidated", 4, 0);
    // R9: snoop miss
    snoop(ad(7, 20, 0));
    traffic("R9 snoop miss", 0, 0);
    chk("R9 snoop miss no retry", 64'(n_retry - s_retry), 64'd0);
    cpu_op(0, 0, ad(6, 20, 1), 0, "R9 line kept");
    traffic("R9 line kept", 0, 0);

    repeat (4) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule